// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps an 8-bit modem status image for a serial port. Its high half shows the present level of four incoming modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Its low half holds sticky change flags, one for each line. The lines are brought in through a two-flop synchronizer. A small mode sequencer decides on each cycle whether the synchronized lines are compared against the stored image to raise change flags, copied in silently, or ignored. The block also owns the 5-bit modem control register. That register drives the four control outputs and a loopback switch.

Software reaches both registers through a byte-wide read/write port. Address 0 is the control register and address 1 is the status image. Read data is registered. Reading the status image returns it and clears its change flags. A `delta_pend` output tells an interrupt unit that at least one change flag is set. In loopback, a status read returns the control outputs cross-mapped onto the line positions, and the stored flags are left alone.

The mode sequencer has three states. SETTLE copies the synchronized lines into the high half and raises no flags. TRACK compares and flags. LOOP freezes the image. The transitions are as follows:
- settle-done: SETTLE goes to TRACK, or to LOOP if loopback is on.
- loop-enter: TRACK goes to LOOP when the loopback bit is set.
- loop-exit: LOOP goes to SETTLE when the loopback bit clears.

Reset enters SETTLE.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, with lines driven DCD=1, RI=0, DSR=1, CTS=1, the status image reads 0xB0, the control register reads 0x08 and `delta_pend` is 0.
- R2: The control register keeps only write-data bits 4..0 (bits 7..5 read as 0). The outputs map from it as follows: DTR from bit 0, RTS from bit 1, OUT1 from bit 2, OUT2 from bit 3 and loopback from bit 4.
- R3: In TRACK, the high half holds DCD in bit 7, RI in bit 6, DSR in bit 5 and CTS in bit 4. A line change shows in a read issued three clock edges after the input changes.
- R4: A rise or a fall of CTS, DSR or DCD sets bit 0, bit 1 or bit 3 respectively, and the bit stays set until a status read.
- R5: Bit 2 is set only when RI falls from 1 to 0, never when it rises.
- R6: A status read outside loopback returns the image as it was before the read edge, then clears bits 3..0 and leaves bits 7..4 unchanged.
- R7: A change flag raised on the same edge as a status read is kept set, while flags that were already set are cleared by that read.
- R8: `delta_pend` is high exactly when any of status bits 3..0 is set.
- R9: In loopback, a status read returns OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5, RTS in bit 4, and 0 in bits 3..0.
- R10: In loopback, line changes set no flag and status reads clear no flag.
- R11: After reset and after leaving loopback, a settle window of SYNC_STAGES+1 cycles loads the lines into bits 7..4 without setting any flag.
- R12: Writes to the status address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| line_cts | input | 1 | Clear-to-send line (asynchronous) |
| line_dsr | input | 1 | Data-set-ready line |
| line_ri | input | 1 | Ring indicator line |
| line_dcd | input | 1 | Carrier detect line |
| ctl_dtr | output | 1 | Data-terminal-ready control output |
| ctl_rts | output | 1 | Request-to-send control output |
| ctl_out1 | output | 1 | General control output 1 |
| ctl_out2 | output | 1 | General control output 2 |
| loop_mode | output | 1 | Loopback switch |
| delta_pend | output | 1 | Any change flag set |

## Verification
A status read and a synchronized line change can land on the same clock edge. The clearing of the old flags then competes with the setting of a new one. The bench first leaves a DSR flag pending. It then changes CTS and times the read strobe to the edge where that change reaches the image. It judges the result in two steps. The read must return the old image, which still carries the DSR flag. A following read must then show only the new CTS flag.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOOP   = 2'd2
    } msr_mode_e;

    // line positions within a nibble (status high half and change flags)
    localparam int LINE_CTS = 0;
    localparam int LINE_DSR = 1;
    localparam int LINE_RI  = 2;
    localparam int LINE_DCD = 3;
    localparam int NUM_LINES = 4;

    // control register bit positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;
    localparam int CTL_W    = 5;

    localparam logic [NUM_LINES-1:0] LINES_RESET = 4'b1011;
    localparam logic [CTL_W-1:0]     CTL_RESET   = 5'b01000;

    // loopback: control outputs seen as line states
    function automatic logic [NUM_LINES-1:0] loop_lines(input logic [CTL_W-1:0] c);
        logic [NUM_LINES-1:0] m;
        m[LINE_CTS] = c[CTL_RTS];
        m[LINE_DSR] = c[CTL_DTR];
        m[LINE_RI]  = c[CTL_OUT1];
        m[LINE_DCD] = c[CTL_OUT2];
        return m;
    endfunction

endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RESET_VAL;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msr_mode_fsm.sv
module msr_mode_fsm
    import msr_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_req,
    output logic track_en,
    output logic load_en,
    output logic in_loop,
    output logic in_settle
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    msr_mode_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic settle_done;

    assign settle_done = (cnt_q == LAST);

    // state register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q != ST_SETTLE) cnt_q <= '0;
            else cnt_q <= cnt_q + CW'(1);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (settle_done) state_d = loop_req ? ST_LOOP : ST_TRACK;
            ST_TRACK:  if (loop_req) state_d = ST_LOOP;
            ST_LOOP:   if (!loop_req) state_d = ST_SETTLE;
            default:   state_d = ST_SETTLE;
        endcase
    end

    // outputs
    always_comb begin
        track_en  = (state_q == ST_TRACK) && !loop_req;
        load_en   = (state_q == ST_SETTLE);
        in_loop   = (state_q == ST_LOOP);
        in_settle = (state_q == ST_SETTLE);
    end
endmodule

// File: rtl/msr_status_reg.sv
module msr_status_reg
    import msr_pkg::*;
#(
    parameter int NL = NUM_LINES,
    parameter logic [NL-1:0] RESET_LINES = LINES_RESET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   lines,
    input  logic            track_en,
    input  logic            load_en,
    input  logic            rd_clear,
    output logic [2*NL-1:0] status_q
);
    logic [NL-1:0] level_q, flag_q, events, level_d, flag_d;

    // per-line change detection; ring flags only its trailing edge
    for (genvar g = 0; g < NL; g++) begin : g_evt
        if (g == LINE_RI) begin : g_trail
            assign events[g] = track_en && level_q[g] && !lines[g];
        end else begin : g_any
            assign events[g] = track_en && (level_q[g] ^ lines[g]);
        end
    end

    always_comb begin
        level_d = (track_en || load_en) ? lines : level_q;
        flag_d  = (rd_clear ? '0 : flag_q) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= RESET_LINES;
            flag_q  <= '0;
        end else begin
            level_q <= level_d;
            flag_q  <= flag_d;
        end
    end

    assign status_q = {level_q, flag_q};
endmodule

// File: rtl/msr_ctrl_reg.sv
module msr_ctrl_reg
    import msr_pkg::*;
#(
    parameter int W = CTL_W,
    parameter logic [W-1:0] RESET_VAL = CTL_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RESET_VAL;
        else if (wr_en) ctl_q <= wdata;
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_ri,
    input  logic              line_dcd,
    output logic              ctl_dtr,
    output logic              ctl_rts,
    output logic              ctl_out1,
    output logic              ctl_out2,
    output logic              loop_mode,
    output logic              delta_pend
);
    localparam int DATA_W = 8;
    localparam int NL = NUM_LINES;
    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(1);

    logic [NL-1:0]     raw_lines, sync_lines;
    logic [CTL_W-1:0]  ctl_q;
    logic [2*NL-1:0]   status_q;
    logic              track_en, load_en, mode_loop, mode_settle;
    logic              rd_status, rd_clear, wr_ctrl;
    logic [DATA_W-1:0] rd_value;

    always_comb begin
        raw_lines[LINE_CTS] = line_cts;
        raw_lines[LINE_DSR] = line_dsr;
        raw_lines[LINE_RI]  = line_ri;
        raw_lines[LINE_DCD] = line_dcd;
    end

    msr_line_sync #(.WIDTH(NL), .STAGES(SYNC_STAGES), .RESET_VAL(LINES_RESET)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines));

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

    msr_ctrl_reg #(.W(CTL_W), .RESET_VAL(CTL_RESET)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
        .wdata(bus_wdata[CTL_W-1:0]), .ctl_q(ctl_q));

    msr_mode_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .loop_req(ctl_q[CTL_LOOP]),
        .track_en(track_en), .load_en(load_en),
        .in_loop(mode_loop), .in_settle(mode_settle));

    assign rd_status = bus_rd && (bus_addr == ADDR_STATUS);
    assign rd_clear  = rd_status && !ctl_q[CTL_LOOP];

    msr_status_reg #(.NL(NL), .RESET_LINES(LINES_RESET)) stat_i (
        .clk(clk), .rst_n(rst_n), .lines(sync_lines),
        .track_en(track_en), .load_en(load_en), .rd_clear(rd_clear),
        .status_q(status_q));

    always_comb begin
        rd_value = '0;
        if (bus_addr == ADDR_CTRL) begin
            rd_value[CTL_W-1:0] = ctl_q;
        end else if (bus_addr == ADDR_STATUS) begin
            if (ctl_q[CTL_LOOP]) rd_value = {loop_lines(ctl_q), {NL{1'b0}}};
            else rd_value = status_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_value;
    end

    assign ctl_dtr    = ctl_q[CTL_DTR];
    assign ctl_rts    = ctl_q[CTL_RTS];
    assign ctl_out1   = ctl_q[CTL_OUT1];
    assign ctl_out2   = ctl_q[CTL_OUT2];
    assign loop_mode  = ctl_q[CTL_LOOP];
    assign delta_pend = |status_q[NL-1:0];
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
    parameter int ADDR_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              loop_mode,
    input logic              delta_pend,
    input logic [7:0]        status_q,
    input logic              mode_loop,
    input logic              mode_settle
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);

    a_r5_ri_trailing_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[2]) |-> ($past(status_q[6]) && !status_q[6]));

    a_r6_clear_only_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(delta_pend) |-> $past(bus_rd && bus_addr == A_STATUS && !loop_mode));

    a_r10_loop_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mode_loop |=> ((status_q[3:0] & ~$past(status_q[3:0])) == 4'b0));

    a_r11_settle_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mode_settle |=> ((status_q[3:0] & ~$past(status_q[3:0])) == 4'b0));

    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CTRL) |=> (bus_rdata[7:5] == 3'b0));

    a_r9_loop_read_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STATUS && loop_mode) |=> (bus_rdata[3:0] == 4'b0));
endmodule

bind modem_status_unit msr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .loop_mode(loop_mode), .delta_pend(delta_pend),
    .status_q(status_q), .mode_loop(mode_loop), .mode_settle(mode_settle));

// File: tb/modem_status_unit_tb_top.sv
module modem_status_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] lines = 4'b1011;  // {dcd, ri, dsr, cts}
    logic ctl_dtr, ctl_rts, ctl_out1, ctl_out2, loop_mode, delta_pend;
    int checks = 0, fails = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    modem_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_cts(lines[0]), .line_dsr(lines[1]), .line_ri(lines[2]), .line_dcd(lines[3]),
        .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
        .loop_mode(loop_mode), .delta_pend(delta_pend));

    // {new lines, expected status read}
    localparam logic [11:0] STEPS [8] = '{
        {4'b1010, 8'hA1}, {4'b1110, 8'hE0}, {4'b1010, 8'hA4}, {4'b0000, 8'h0A},
        {4'b1111, 8'hFB}, {4'b1111, 8'hF0}, {4'b0101, 8'h5A}, {4'b0001, 8'h14}};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        clks(4);
        check("R1 delta_pend after reset", {7'b0, delta_pend}, 8'h00);
        rd(1'b0, rv); check("R1 control reset", rv, 8'h08);
        rd(1'b1, rv); check("R1 status reset", rv, 8'hB0);

        foreach (STEPS[i]) begin
            lines = STEPS[i][11:8];
            clks(3);
            check("R8 delta_pend before read", {7'b0, delta_pend}, {7'b0, STEPS[i][3:0] != 4'b0});
            rd(1'b1, rv);
            check("R3/R4/R5 table step", rv, STEPS[i][7:0]);
            check("R6 delta_pend after read", {7'b0, delta_pend}, 8'h00);
        end

        // R6: second read keeps the high half and shows no flags
        lines = 4'b0000; clks(3);
        rd(1'b1, rv); check("R6 first read", rv, 8'h01);
        rd(1'b1, rv); check("R6 second read", rv, 8'h00);

        // R7: read on the edge where a new change lands
        lines = 4'b0010; clks(3);
        lines = 4'b0011;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(1'b1, rv); check("R7 read sees old image", rv, 8'h22);
        rd(1'b1, rv); check("R7 new flag kept", rv, 8'h31);

        // R12: write to status address ignored
        lines = 4'b0001; clks(3);
        wr(1'b1, 8'h00);
        check("R12 delta_pend after write", {7'b0, delta_pend}, 8'h01);
        rd(1'b1, rv); check("R12 status unchanged", rv, 8'h12);

        // R2: control width and output mapping
        wr(1'b0, 8'hE3);
        rd(1'b0, rv); check("R2 control low bits", rv, 8'h03);
        check("R2 output pins", {3'b0, loop_mode, ctl_out2, ctl_out1, ctl_rts, ctl_dtr}, 8'h03);

        // pending CTS flag before loopback
        lines = 4'b0000; clks(3);
        check("R8 flag pending", {7'b0, delta_pend}, 8'h01);

        // R9: loopback cross-mapping
        wr(1'b0, 8'h12); rd(1'b1, rv); check("R9 RTS to CTS", rv, 8'h10);
        wr(1'b0, 8'h11); rd(1'b1, rv); check("R9 DTR to DSR", rv, 8'h20);
        wr(1'b0, 8'h14); rd(1'b1, rv); check("R9 OUT1 to RI", rv, 8'h40);
        wr(1'b0, 8'h18); rd(1'b1, rv); check("R9 OUT2 to DCD", rv, 8'h80);
        wr(1'b0, 8'hFF); rd(1'b0, rv); check("R2 control all ones", rv, 8'h1F);
        rd(1'b1, rv); check("R9 all outputs", rv, 8'hF0);
        check("R2 output pins all", {3'b0, loop_mode, ctl_out2, ctl_out1, ctl_rts, ctl_dtr}, 8'h1F);

        // R10: loopback leaves flags alone; R11: exit settles silently
        lines = 4'b1111; clks(4);
        check("R10 flag kept in loop", {7'b0, delta_pend}, 8'h01);
        wr(1'b0, 8'h08); clks(6);
        rd(1'b1, rv); check("R10/R11 after loop exit", rv, 8'hF1);

        // R11: reset with lines away from reset pattern
        lines = 4'b0100; rst_n = 1'b0; clks(2);
        rst_n = 1'b1; clks(5);
        check("R11 delta_pend after reset", {7'b0, delta_pend}, 8'h00);
        rd(1'b1, rv); check("R11 status after settle", rv, 8'h40);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule